// File: doc/BRIEF.md
# Multi-Mode Pixel Clock Strobe Generator

This block turns a stream of video clock enables into the timing for the pixel clock sent to a display. Each display output mode packs a different number of pixels into one pixel clock, so the block spaces its pixel clock strobes 1, 2, 4 or 8 video clock enables apart. It also has one fractional mode that averages 2-2/3 enables per strobe. In that mode the spans between strobes follow a fixed 3, 2, 3 sequence. The sequence repeats every 8 video clock enables.

All logic runs on one system clock. `vclk_en_i` marks the cycles that count as video clocks. The block gives three results. `spclk_en_o` is a strobe in the same cycle as the enable that ends a span. `spclk_o` is a registered clock level for the display pin. `phase_o` shows which span of the fractional sequence is in progress. A new mode code is taken only where a pattern starts, so every span has its full length.

Top module: `pclk_gen`

## Requirements
- R1: While `rst_ni` is low and `vclk_en_i` is low, `spclk_en_o`, `spclk_o` and `phase_o` are all 0. After reset the block is at the start of a pattern.
- R2: Mode code 3'b000 (1 pixel) makes every span 1 enable long, so `spclk_en_o` is high on every video clock enable.
- R3: Mode code 3'b001 (2 pixels) makes every span 2 enables long. `spclk_en_o` is high on every second enable.
- R4: Mode code 3'b010 (4 pixels) makes every span 4 enables long, and mode code 3'b011 (8 pixels) makes every span 8 enables long.
- R5: Mode code 3'b100 (2-2/3 pixels) makes spans of 3, then 2, then 3 enables. This sequence repeats every 8 enables.
- R6: `phase_o` is 0, 1 and 2 during the first, second and third span of the 2-2/3 sequence. It returns to 0 after the third span. In all other modes it stays 0.
- R7: After a clock edge with an enable at position k (counted from 0) of a span of length L, `spclk_o` is high exactly when k < ceil(L/2). `spclk_o` holds its value in cycles without an enable.
- R8: `mode_i` is sampled only on the first enable of a pattern. A pattern is one span, or all three spans in 2-2/3 mode. A change to `mode_i` at any other time is ignored until the next pattern starts.
- R9: Mode codes 3'b101, 3'b110 and 3'b111 behave exactly like code 3'b000.
- R10: In a cycle with `vclk_en_i` low, `spclk_en_o` is 0 and neither the position in the span nor `phase_o` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vclk_en_i | input | 1 | Video clock enable; one high cycle is one video clock |
| mode_i | input | 3 | Output mode code: 000=1, 001=2, 010=4, 011=8, 100=2-2/3 pixels per pixel clock |
| spclk_en_o | output | 1 | Pixel clock strobe, high on the last enable of each span |
| spclk_o | output | 1 | Registered pixel clock level |
| phase_o | output | 2 | Index of the current span within the 2-2/3 sequence |

## Verification
`spclk_en_o` is combinational, so it is due in the same cycle as the enable that ends a span. The bench therefore compares it at the falling edge that follows the input change. `spclk_o` and `phase_o` are registered, so they are due one rising edge after the enable that causes them. The reference model updates its own copies of these two only at that rising edge and compares them at the next falling edge. The model stores each pattern as a queue of span lengths that it fills from the mode code when the queue runs empty. Because of this, a mid-span mode change, gaps in the enables and unused codes are all checked against the same timing.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  localparam int MAX_SPAN = 8;
  localparam int CNT_W    = $clog2(MAX_SPAN);
  localparam int LEN_W    = CNT_W + 1;
  localparam int MODE_W   = 3;
  localparam int PH_W     = 2;
  localparam int FRAC_SPANS = 3;

  localparam logic [MODE_W-1:0] PM_X1   = 3'b000;
  localparam logic [MODE_W-1:0] PM_X2   = 3'b001;
  localparam logic [MODE_W-1:0] PM_X4   = 3'b010;
  localparam logic [MODE_W-1:0] PM_X8   = 3'b011;
  localparam logic [MODE_W-1:0] PM_FRAC = 3'b100;

  // span length in video clocks for a mode and sequence phase
  function automatic logic [LEN_W-1:0] span_len(input logic [MODE_W-1:0] m,
                                                input logic [PH_W-1:0] ph);
    case (m)
      PM_X2:   span_len = LEN_W'(2);
      PM_X4:   span_len = LEN_W'(4);
      PM_X8:   span_len = LEN_W'(MAX_SPAN);
      PM_FRAC: span_len = (ph == PH_W'(1)) ? LEN_W'(2) : LEN_W'(3);
      default: span_len = LEN_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/pclk_mode_sel.sv
module pclk_mode_sel
  import pclk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vclk_en_i,
  input  logic              at_start_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [MODE_W-1:0] eff_mode_o
);
  logic [MODE_W-1:0] mode_q;

  // live code at a pattern start, held code inside a pattern
  assign eff_mode_o = at_start_i ? mode_i : mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      mode_q <= PM_X1;
    else if (vclk_en_i && at_start_i) mode_q <= mode_i;
  end
endmodule

// File: rtl/pclk_span_ctr.sv
module pclk_span_ctr
  import pclk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vclk_en_i,
  input  logic [MODE_W-1:0] eff_mode_i,
  output logic              last_o,
  output logic              first_half_o,
  output logic              at_start_o,
  output logic [PH_W-1:0]   phase_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [PH_W-1:0]  phase_q;
  logic [LEN_W-1:0] len;
  logic [LEN_W-1:0] half;
  logic             frac_wrap;

  assign len          = span_len(eff_mode_i, phase_q);
  assign half         = (len + 1'b1) >> 1;
  assign last_o       = ({1'b0, cnt_q} == (len - {{CNT_W{1'b0}}, 1'b1}));
  assign first_half_o = ({1'b0, cnt_q} < half);
  assign at_start_o   = (cnt_q == '0) && (phase_q == '0);
  assign phase_o      = phase_q;
  assign frac_wrap    = (phase_q == PH_W'(FRAC_SPANS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= '0;
    end else if (vclk_en_i) begin
      if (last_o) begin
        cnt_q <= '0;
        if (eff_mode_i == PM_FRAC && !frac_wrap) phase_q <= phase_q + 1'b1;
        else                                     phase_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pclk_level_reg.sv
module pclk_level_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vclk_en_i,
  input  logic level_i,
  output logic level_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        level_o <= 1'b0;
    else if (vclk_en_i) level_o <= level_i;
  end
endmodule

// File: rtl/pclk_gen.sv
module pclk_gen
  import pclk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vclk_en_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              spclk_en_o,
  output logic              spclk_o,
  output logic [PH_W-1:0]   phase_o
);
  logic [MODE_W-1:0] eff_mode;
  logic              at_start;
  logic              last;
  logic              first_half;

  pclk_mode_sel u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vclk_en_i  (vclk_en_i),
    .at_start_i (at_start),
    .mode_i     (mode_i),
    .eff_mode_o (eff_mode)
  );

  pclk_span_ctr u_ctr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .vclk_en_i    (vclk_en_i),
    .eff_mode_i   (eff_mode),
    .last_o       (last),
    .first_half_o (first_half),
    .at_start_o   (at_start),
    .phase_o      (phase_o)
  );

  pclk_level_reg u_lvl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vclk_en_i (vclk_en_i),
    .level_i   (first_half),
    .level_o   (spclk_o)
  );

  assign spclk_en_o = vclk_en_i && last;
endmodule

// File: rtl/pclk_gen_chk.sv
module pclk_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       vclk_en_i,
  input logic       spclk_en_o,
  input logic       spclk_o,
  input logic [1:0] phase_o
);
  // R10
  strobe_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spclk_en_o |-> vclk_en_i);

  // R10
  phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vclk_en_i |=> $stable(phase_o));

  // R7
  level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vclk_en_i |=> $stable(spclk_o));

  // R6
  phase_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o != 2'd3);

  // R6
  phase_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spclk_en_o && phase_o == 2'd2) |=> phase_o == 2'd0);

  // R6
  phase_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vclk_en_i && !spclk_en_o) |=> $stable(phase_o));
endmodule

bind pclk_gen pclk_gen_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .vclk_en_i  (vclk_en_i),
  .spclk_en_o (spclk_en_o),
  .spclk_o    (spclk_o),
  .phase_o    (phase_o)
);

// File: tb/sim_pclk_gen.sv
`timescale 1ns/1ps
module sim_pclk_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vclk_en = 1'b0;
  logic [2:0] mode = 3'b000;
  logic       spclk_en;
  logic       spclk;
  logic [1:0] phase;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // reference state
  int spans[$];
  int pos     = 0;
  int span_ix = 0;
  bit m_lvl   = 1'b0;

  always #4 clk = ~clk;

  pclk_gen u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .vclk_en_i  (vclk_en),
    .mode_i     (mode),
    .spclk_en_o (spclk_en),
    .spclk_o    (spclk),
    .phase_o    (phase)
  );

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic fill(input logic [2:0] md);
    case (md)
      3'b001:  spans.push_back(2);
      3'b010:  spans.push_back(4);
      3'b011:  spans.push_back(8);
      3'b100:  begin spans.push_back(3); spans.push_back(2); spans.push_back(3); end
      default: spans.push_back(1);
    endcase
  endtask

  task automatic step(input bit en, input logic [2:0] md, input string tag);
    int len;
    bit exp_pulse;
    vclk_en = en;
    mode    = md;
    @(negedge clk);
    if (en && spans.size() == 0) fill(md);
    len = (spans.size() != 0) ? spans[0] : 1;
    exp_pulse = en && (pos == len - 1);
    cmp(tag, "spclk_en", int'(spclk_en), int'(exp_pulse));
    cmp(tag, "phase", int'(phase), span_ix);
    cmp(tag, "spclk", int'(spclk), int'(m_lvl));
    @(posedge clk);
    if (en) begin
      m_lvl = (pos < (len + 1) / 2);
      pos++;
      if (pos == len) begin
        pos = 0;
        void'(spans.pop_front());
        span_ix++;
        if (spans.size() == 0) span_ix = 0;
      end
    end
    #1;
  endtask

  task automatic run(input int n, input logic [2:0] md, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, md, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    cmp("R1", "spclk_en", int'(spclk_en), 0);
    cmp("R1", "spclk", int'(spclk), 0);
    cmp("R1", "phase", int'(phase), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    run(10, 3'b000, "R2");
    run(6, 3'b001, "R3");
    // R10 gaps inside 2-pixel spans
    for (int i = 0; i < 12; i++) step(i % 3 != 0, 3'b001, "R10");
    run(12, 3'b010, "R4");
    run(24, 3'b011, "R4");
    run(24, 3'b100, "R5");
    // R6 phase with idle cycles inside the 3-2-3 sequence
    for (int i = 0; i < 30; i++) step(i % 4 != 1, 3'b100, "R6");
    // R8 change mid-span: 8-pixel span must complete first
    run(3, 3'b011, "R8");
    run(9, 3'b001, "R8");
    // R8 change mid-sequence in fractional mode
    run(2, 3'b100, "R8");
    run(10, 3'b010, "R8");
    run(4, 3'b000, "R7");
    run(3, 3'b101, "R9");
    run(3, 3'b110, "R9");
    run(3, 3'b111, "R9");
    run(8, 3'b010, "R7");
    for (int i = 0; i < 40; i++) step((i * 7) % 5 < 3, 3'((i / 8) % 5), "R10");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule